// File: doc/BRIEF.md
# Control and Debug Register File with Write Side Effects

This block holds the processor's control registers, its debug address and debug status/control registers, the extended-feature register and the time-stamp counter. All of them are selected by a 5-bit index. The block has one write port and one read port. A mode bit on the write port picks between a plain store and an architectural write. An architectural write applies the processor's rules. It keeps the long-mode-active flag in line with paging changes. It forces the bits that must stay fixed. It keeps only the writable fields of the debug status and debug control registers. It folds the two reserved debug indices onto their live counterparts. It keeps the time-stamp counter as an offset from a free-running cycle counter.

Several writes also ask the translation cache to drop its entries. Each such request is a one-cycle pulse on the cycle after the write: one output asks for a full flush, the other for a flush of non-global entries only. An access to an index that names no register raises a one-cycle error pulse and changes nothing. Setting any breakpoint enable in the debug control register raises a pulse that marks an unsupported breakpoint. Breakpoint matching itself is not part of the block.

Index map: 0..15 are control registers 0..15, of which only 0, 2, 3, 4 and 8 exist. 16..23 are debug registers 0..7. 24 is the extended-feature register. 25 is the time-stamp counter. 26..31 are unused.

Top module: `ctlreg_file`

## Requirements
- R1: After reset, every register reads zero except debug status (index 22), which reads 0xFFFF0FF0, and debug control (index 23), which reads 0x00000400. All four pulse outputs are low.
- R2: An architectural write to control register 0 (index 0) always stores bit 4 as 1. If bit 31 (paging) changes while bit 8 of the extended-feature register (index 24) is 1, bit 10 of that register takes the new value of bit 31.
- R3: An architectural write to index 0 that changes bit 31, or to index 4 that changes bit 4, 5 or 7, gives `flush_all` high for exactly the cycle after the write. A write that changes none of these bits leaves it low.
- R4: An architectural write to index 3 stores the data and gives `flush_nonglobal` high for the cycle after the write, with `flush_all` low.
- R5: An access to indices 1, 5-7, 9-15 or 26-31 gives `acc_err` high for the cycle after it. This covers a write of either mode, and a read with `rd_en` high. Such a write changes no register, and a read of such an index returns zero.
- R6: An architectural write of V to the time-stamp counter (index 25) makes architectural reads return V+k, where k is the number of clock edges since the write edge.
- R7: An architectural write to index 22 or to its alias index 20 updates only bits 0-3, 13, 14 and 15 of the debug status register. All other bits keep their value. Reads at index 20 return the debug status register.
- R8: An architectural write to index 23 or to its alias index 21 updates only bits 0-7, bit 13 and bits 16-31 of the debug control register. All other bits, including bit 10, keep their value.
- R9: An architectural write to index 21 or 23 with any of data bits 0-7 set gives `bkpt_unsup` high for the cycle after the write. Otherwise it stays low.
- R10: A plain write (`wr_fx` low) stores the data unchanged at any legal index and raises no flush or breakpoint pulse. A plain read of index 25 returns the stored offset, not the offset plus the cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_fx | input | 1 | 1 = architectural write, 0 = plain store |
| wr_idx | input | 5 | Write index |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe, used only to report illegal reads |
| rd_fx | input | 1 | 1 = architectural read (counter adds cycle count) |
| rd_idx | input | 5 | Read index |
| rd_data | output | DATA_W | Read data, combinational from the index |
| flush_all | output | 1 | Full translation-flush request pulse |
| flush_nonglobal | output | 1 | Non-global translation-flush request pulse |
| bkpt_unsup | output | 1 | Breakpoint-enable-written pulse |
| acc_err | output | 1 | Illegal-index access pulse |

## Verification
The hardest case to reach from the ports is the paging toggle that updates the long-mode-active flag. It needs the extended-feature register preloaded through a plain write, then architectural writes that set and clear paging. Both register contents are read back after each step. A repeated write with an unchanged paging bit shows that nothing happens without a change. The flush and masking rules are covered by random control-register-4, debug-status and debug-control writes, checked against a bench model of the previous value. The time-stamp offset is checked only through differences between reads, so the bench never needs the internal cycle count.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam int IDX_W = 5;

    // index map
    localparam logic [IDX_W-1:0] IX_CR0  = 5'd0;
    localparam logic [IDX_W-1:0] IX_CR2  = 5'd2;
    localparam logic [IDX_W-1:0] IX_CR3  = 5'd3;
    localparam logic [IDX_W-1:0] IX_CR4  = 5'd4;
    localparam logic [IDX_W-1:0] IX_CR8  = 5'd8;
    localparam logic [IDX_W-1:0] IX_DR0  = 5'd16;
    localparam logic [IDX_W-1:0] IX_DR1  = 5'd17;
    localparam logic [IDX_W-1:0] IX_DR2  = 5'd18;
    localparam logic [IDX_W-1:0] IX_DR3  = 5'd19;
    localparam logic [IDX_W-1:0] IX_DR4  = 5'd20;
    localparam logic [IDX_W-1:0] IX_DR5  = 5'd21;
    localparam logic [IDX_W-1:0] IX_DR6  = 5'd22;
    localparam logic [IDX_W-1:0] IX_DR7  = 5'd23;
    localparam logic [IDX_W-1:0] IX_EFER = 5'd24;
    localparam logic [IDX_W-1:0] IX_TSC  = 5'd25;

    // bit positions used by the write rules
    localparam int B_CR0_PG   = 31;
    localparam int B_CR0_ET   = 4;
    localparam int B_EFER_LME = 8;
    localparam int B_EFER_LMA = 10;

    localparam logic [31:0] CR4_FLUSH_M = 32'h0000_00B0; // PSE, PAE, PGE
    localparam logic [31:0] DBGSTS_WM   = 32'h0000_E00F;
    localparam logic [31:0] DBGCTL_WM   = 32'hFFFF_20FF;
    localparam logic [31:0] DBGSTS_RST  = 32'hFFFF_0FF0;
    localparam logic [31:0] DBGCTL_RST  = 32'h0000_0400;

    typedef enum logic [3:0] {
        SL_CR0, SL_CR2, SL_CR3, SL_CR4, SL_CR8,
        SL_DR0, SL_DR1, SL_DR2, SL_DR3, SL_DSTS, SL_DCTL,
        SL_EFER, SL_TSC
    } slot_e;

    localparam int NUM_SLOTS = 13;

    typedef struct packed {
        logic  legal;
        slot_e slot;
    } dec_t;

    function automatic dec_t decode_idx(input logic [IDX_W-1:0] idx);
        dec_t d;
        d.legal = 1'b1;
        d.slot  = SL_CR0;
        case (idx)
            IX_CR0:         d.slot = SL_CR0;
            IX_CR2:         d.slot = SL_CR2;
            IX_CR3:         d.slot = SL_CR3;
            IX_CR4:         d.slot = SL_CR4;
            IX_CR8:         d.slot = SL_CR8;
            IX_DR0:         d.slot = SL_DR0;
            IX_DR1:         d.slot = SL_DR1;
            IX_DR2:         d.slot = SL_DR2;
            IX_DR3:         d.slot = SL_DR3;
            IX_DR4, IX_DR6: d.slot = SL_DSTS;
            IX_DR5, IX_DR7: d.slot = SL_DCTL;
            IX_EFER:        d.slot = SL_EFER;
            IX_TSC:         d.slot = SL_TSC;
            default:        d.legal = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic [31:0] slot_reset(input slot_e s);
        case (s)
            SL_DSTS: return DBGSTS_RST;
            SL_DCTL: return DBGCTL_RST;
            default: return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
    import ctlreg_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output dec_t             dec
);
    always_comb dec = decode_idx(idx);
endmodule

// File: rtl/ctlreg_cyc.sv
module ctlreg_cyc #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ctlreg_fx.sv
module ctlreg_fx
    import ctlreg_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         fx,
    input  slot_e        slot,
    input  logic [W-1:0] data,
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] efer_old,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] new_val,
    output logic         efer_upd,
    output logic [W-1:0] efer_new,
    output logic         fl_all,
    output logic         fl_ng,
    output logic         bkpt
);
    localparam logic [W-1:0] M_CR4  = W'(CR4_FLUSH_M);
    localparam logic [W-1:0] M_DSTS = W'(DBGSTS_WM);
    localparam logic [W-1:0] M_DCTL = W'(DBGCTL_WM);

    logic [W-1:0] tog;
    assign tog = old_val ^ data;

    always_comb begin
        new_val  = data;
        efer_upd = 1'b0;
        efer_new = efer_old;
        fl_all   = 1'b0;
        fl_ng    = 1'b0;
        bkpt     = 1'b0;
        if (fx) begin
            case (slot)
                SL_CR0: begin
                    if (tog[B_CR0_PG]) begin
                        fl_all = 1'b1;
                        if (efer_old[B_EFER_LME]) begin
                            efer_upd = 1'b1;
                            efer_new[B_EFER_LMA] = data[B_CR0_PG];
                        end
                    end
                    new_val[B_CR0_ET] = 1'b1;
                end
                SL_CR3: fl_ng = 1'b1;
                SL_CR4: fl_all = |(tog & M_CR4);
                SL_DSTS: new_val = (old_val & ~M_DSTS) | (data & M_DSTS);
                SL_DCTL: begin
                    new_val = (old_val & ~M_DCTL) | (data & M_DCTL);
                    bkpt    = |data[7:0];
                end
                SL_TSC: new_val = data - cnt;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file
    import ctlreg_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_fx,
    input  logic [4:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_fx,
    input  logic [4:0]        rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              flush_all,
    output logic              flush_nonglobal,
    output logic              bkpt_unsup,
    output logic              acc_err
);
    dec_t              wdec, rdec;
    logic [DATA_W-1:0] cnt;
    logic [DATA_W-1:0] regs_q [NUM_SLOTS];
    logic [DATA_W-1:0] new_val, efer_new;
    logic              efer_upd, fx_all, fx_ng, fx_bk, wr_ok;
    logic [DATA_W-1:0] cr0_view, dctl_view;

    ctlreg_decode u_wdec (.idx(wr_idx), .dec(wdec));
    ctlreg_decode u_rdec (.idx(rd_idx), .dec(rdec));
    ctlreg_cyc #(.W(DATA_W)) u_cyc (.clk(clk), .rst(rst), .cnt(cnt));

    ctlreg_fx #(.W(DATA_W)) u_fx (
        .fx(wr_fx), .slot(wdec.slot), .data(wr_data),
        .old_val(regs_q[wdec.slot]), .efer_old(regs_q[SL_EFER]), .cnt(cnt),
        .new_val(new_val), .efer_upd(efer_upd), .efer_new(efer_new),
        .fl_all(fx_all), .fl_ng(fx_ng), .bkpt(fx_bk)
    );

    assign wr_ok = wr_en & wdec.legal;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam slot_e SID = slot_e'(s);
        logic [DATA_W-1:0] q;
        logic              hit;
        assign hit = wr_ok & (wdec.slot == SID);
        always_ff @(posedge clk) begin
            if (rst)
                q <= DATA_W'(slot_reset(SID));
            else if (SID == SL_EFER && wr_ok && efer_upd)
                q <= efer_new;
            else if (hit)
                q <= new_val;
        end
        assign regs_q[s] = q;
    end

    always_comb begin
        if (!rdec.legal)
            rd_data = '0;
        else if (rd_fx && rdec.slot == SL_TSC)
            rd_data = regs_q[SL_TSC] + cnt;
        else
            rd_data = regs_q[rdec.slot];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_all       <= 1'b0;
            flush_nonglobal <= 1'b0;
            bkpt_unsup      <= 1'b0;
            acc_err         <= 1'b0;
        end else begin
            flush_all       <= wr_ok & fx_all;
            flush_nonglobal <= wr_ok & fx_ng;
            bkpt_unsup      <= wr_ok & fx_bk;
            acc_err         <= (wr_en & ~wdec.legal) | (rd_en & ~rdec.legal);
        end
    end

    assign cr0_view  = regs_q[SL_CR0];
    assign dctl_view = regs_q[SL_DCTL];
endmodule

// File: rtl/ctlreg_chk.sv
module ctlreg_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic         wr_fx,
    input logic [4:0]   wr_idx,
    input logic [W-1:0] wr_data,
    input logic         flush_all,
    input logic         flush_nonglobal,
    input logic         bkpt_unsup,
    input logic         acc_err,
    input logic         cr0_et,
    input logic         dctl_b10
);
    logic fxw;
    assign fxw = wr_en & wr_fx;

    AST_ET_FORCED: assert property (@(posedge clk) disable iff (rst)
        (fxw && wr_idx == 5'd0) |=> cr0_et); // R2
    AST_FLUSH_SRC: assert property (@(posedge clk) disable iff (rst)
        flush_all |-> $past(fxw && (wr_idx == 5'd0 || wr_idx == 5'd4))); // R3
    AST_NG_ONLY: assert property (@(posedge clk) disable iff (rst)
        (fxw && wr_idx == 5'd3) |=> (flush_nonglobal && !flush_all)); // R4
    AST_NG_SRC: assert property (@(posedge clk) disable iff (rst)
        flush_nonglobal |-> $past(fxw && wr_idx == 5'd3)); // R4
    AST_ILLEGAL_WR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_idx == 5'd1 || wr_idx == 5'd9 || wr_idx == 5'd31)) |=> acc_err); // R5
    AST_DCTL_FIXED: assert property (@(posedge clk) disable iff (rst)
        (fxw && (wr_idx == 5'd21 || wr_idx == 5'd23)) |=> (dctl_b10 == $past(dctl_b10))); // R8
    AST_BKPT_SRC: assert property (@(posedge clk) disable iff (rst)
        bkpt_unsup |-> $past(fxw && (wr_idx == 5'd21 || wr_idx == 5'd23) && (|wr_data[7:0]))); // R9
    AST_RAW_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_fx) |=> (!flush_all && !flush_nonglobal && !bkpt_unsup)); // R10
endmodule

bind ctlreg_file ctlreg_chk #(.W(DATA_W)) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_fx(wr_fx), .wr_idx(wr_idx),
    .wr_data(wr_data), .flush_all(flush_all), .flush_nonglobal(flush_nonglobal),
    .bkpt_unsup(bkpt_unsup), .acc_err(acc_err),
    .cr0_et(cr0_view[4]), .dctl_b10(dctl_view[10])
);

// File: tb/ctlreg_file_tb_top.sv
module ctlreg_file_tb_top;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 0, wr_fx = 0, rd_en = 0, rd_fx = 0;
    logic [4:0]   wr_idx = 0, rd_idx = 0;
    logic [W-1:0] wr_data = 0;
    logic [W-1:0] rd_data;
    logic         flush_all, flush_nonglobal, bkpt_unsup, acc_err;

    int total = 0;
    int bad   = 0;
    logic p_all, p_ng, p_bk, p_err;

    always #2 clk = ~clk;

    ctlreg_file #(.DATA_W(W)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_fx(wr_fx), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_en(rd_en), .rd_fx(rd_fx), .rd_idx(rd_idx),
        .rd_data(rd_data), .flush_all(flush_all), .flush_nonglobal(flush_nonglobal),
        .bkpt_unsup(bkpt_unsup), .acc_err(acc_err)
    );

    localparam logic [W-1:0] M_DSTS = 64'h0000_E00F;
    localparam logic [W-1:0] M_DCTL = 64'hFFFF_20FF;

    function automatic logic [W-1:0] merge(input logic [W-1:0] o, d, m);
        return (o & ~m) | (d & m);
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic fx, input logic [4:0] idx, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_fx = fx; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_fx = 1'b0;
        p_all = flush_all; p_ng = flush_nonglobal; p_bk = bkpt_unsup; p_err = acc_err;
    endtask

    task automatic rd(input logic fx, input logic [4:0] idx, output logic [W-1:0] d);
        rd_fx = fx; rd_idx = idx;
        #1 d = rd_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] v, d, m_cr4, m_sts, m_ctl, t0;
        void'($urandom(32'h1234_5A5A));
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, 5'd0, v);  chk("R1 cr0", v, 0);
        rd(0, 5'd22, v); chk("R1 dbgsts", v, 64'hFFFF_0FF0);
        rd(0, 5'd23, v); chk("R1 dbgctl", v, 64'h0000_0400);
        rd(0, 5'd24, v); chk("R1 efer", v, 0);
        chk("R1 pulses", {flush_all, flush_nonglobal, bkpt_unsup, acc_err}, 0);

        // R2 paging toggle with long-mode enable set
        wr(0, 5'd24, 64'h100);
        wr(1, 5'd0, 64'h8000_0001);
        chk("R3 pg on flush", p_all, 1);
        rd(0, 5'd24, v); chk("R2 lma set", v, 64'h500);
        rd(0, 5'd0, v);  chk("R2 et forced", v, 64'h8000_0011);
        wr(1, 5'd0, 64'h1);
        chk("R3 pg off flush", p_all, 1);
        rd(0, 5'd24, v); chk("R2 lma clear", v, 64'h100);
        wr(1, 5'd0, 64'h11);
        chk("R3 no toggle no flush", p_all, 0);
        rd(0, 5'd24, v); chk("R2 lma unchanged", v, 64'h100);
        wr(0, 5'd24, 64'h0);
        wr(1, 5'd0, 64'h8000_0000);
        chk("R3 pg on flush no lme", p_all, 1);
        rd(0, 5'd24, v); chk("R2 no lme no lma", v, 0);
        rd(0, 5'd0, v);  chk("R2 et forced again", v, 64'h8000_0010);

        // R4
        wr(1, 5'd3, 64'hABCD_E000);
        chk("R4 ng pulse", p_ng, 1);
        chk("R4 no full", p_all, 0);
        rd(0, 5'd3, v); chk("R4 cr3 data", v, 64'hABCD_E000);

        // R3 random control-register-4 writes
        m_cr4 = 0;
        for (int i = 0; i < 40; i++) begin
            d = {32'h0, $urandom};
            if (i % 3 == 0) d = m_cr4 ^ 64'h100;
            wr(1, 5'd4, d);
            chk("R3 cr4 flush", p_all, |((m_cr4 ^ d) & 64'hB0));
            m_cr4 = d;
        end
        rd(0, 5'd4, v); chk("R3 cr4 data", v, m_cr4);

        // R5 illegal indices
        wr(1, 5'd5, 64'hFFFF);
        chk("R5 err fx write", p_err, 1);
        rd(0, 5'd5, v); chk("R5 read zero", v, 0);
        wr(0, 5'd1, 64'h1234);
        chk("R5 err raw write", p_err, 1);
        wr(0, 5'd30, 64'h1234);
        chk("R5 err idx30", p_err, 1);
        rd(0, 5'd0, v); chk("R5 cr0 untouched", v, 64'h8000_0010);
        rd(0, 5'd1, v); chk("R5 read idx1 zero", v, 0);
        @(negedge clk); rd_en = 1'b1; rd_idx = 5'd9;
        @(negedge clk); rd_en = 1'b0;
        chk("R5 err read", acc_err, 1);
        wr(0, 5'd2, 64'h77);
        chk("R5 legal no err", p_err, 0);

        // R6 time-stamp offset
        t0 = 64'h0000_1000_0000_0000;
        wr(1, 5'd25, t0);
        rd(1, 5'd25, v); chk("R6 tsc +1", v, t0 + 1);
        repeat (7) @(negedge clk);
        rd(1, 5'd25, v); chk("R6 tsc +8", v, t0 + 8);

        // R10 plain port
        wr(0, 5'd25, 64'h55);
        rd(0, 5'd25, v); chk("R10 tsc raw", v, 64'h55);
        wr(0, 5'd24, 64'h100);
        wr(0, 5'd0, 64'h0);
        chk("R10 raw no flush", p_all, 0);
        rd(0, 5'd0, v);  chk("R10 raw no et", v, 0);
        rd(0, 5'd24, v); chk("R10 raw no lma", v, 64'h100);
        wr(0, 5'd3, 64'h9);
        chk("R10 raw no ng", p_ng, 0);

        // R7 debug status masking and alias
        m_sts = 64'hFFFF_0FF0;
        for (int i = 0; i < 20; i++) begin
            d = {$urandom, $urandom};
            wr(1, (i % 2 == 0) ? 5'd20 : 5'd22, d);
            m_sts = merge(m_sts, d, M_DSTS);
            rd(0, 5'd22, v); chk("R7 dbgsts", v, m_sts);
        end
        rd(0, 5'd20, v); chk("R7 alias read", v, m_sts);

        // R8 / R9 debug control masking, alias, enable flag
        m_ctl = 64'h400;
        for (int i = 0; i < 20; i++) begin
            d = {$urandom, $urandom};
            if (i % 4 != 0) d[7:0] = 8'h0;
            wr(1, (i % 2 == 0) ? 5'd21 : 5'd23, d);
            chk("R9 bkpt flag", p_bk, |d[7:0]);
            m_ctl = merge(m_ctl, d, M_DCTL);
            rd(0, 5'd23, v); chk("R8 dbgctl", v, m_ctl);
        end
        chk("R8 bit10 kept", m_ctl[10], 1);

        // R10 plain write stores unmasked
        wr(0, 5'd22, {W{1'b1}});
        rd(0, 5'd22, v); chk("R10 raw dbgsts", v, {W{1'b1}});
        wr(0, 5'd23, 64'hFF);
        chk("R10 raw no bkpt", p_bk, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule